// File: doc/BRIEF.md
# Sequential Multi-Level Trigger Engine

This block sits at the front of a logic-analyzer capture path. It watches a word of sampled digital lines that arrives with a valid strobe, and it steps through a chain of programmable levels. Each level holds its own condition: a masked pattern compare, rising and falling edge terms on chosen lines, or any mix of these. The engine looks only at the condition of its current level. When that condition holds on a valid sample it moves to the next level. When the level chosen as the last one matches, it emits a trigger pulse. An event for a later level therefore counts only after every earlier level has been satisfied, in order.

Software programs the levels through a small write port while the engine is disarmed. It then raises `arm`. The current level index is visible on a status output. After a trigger the engine either starts hunting again from level 0, which allows repeated captures, or halts until `arm` is dropped and raised again.

Top module: `trig_seq`

## Requirements
- R1: After reset, and in every cycle that follows a clock edge at which `arm` was low, `trigOut` is 0 and `curLevel` is 0.
- R2: A level's pattern term holds when every line whose care bit is 1 equals the corresponding value bit. Lines whose care bit is 0 are not compared.
- R3: A line with its rise enable set requires a 0 in the previous valid sample and a 1 in the current one. A line with its fall enable set requires a 1 then a 0. A level matches only when its pattern term and all of its enabled edge terms hold on the same valid sample. A level with no terms enabled matches any valid sample.
- R4: The first valid sample after `arm` rises never satisfies an edge term. A level that uses any edge enable cannot match on that sample.
- R5: Hunting starts at level 0. At most one level is evaluated per valid sample, and only the current level's condition is evaluated. On a match the level advances by one. Cycles with `sampleValid` low change nothing.
- R6: A match on the level whose index equals the programmed last-level index makes `trigOut` high for the cycle after that sample's clock edge. `curLevel` returns to 0 at the same edge.
- R7: With auto-rearm set, hunting continues from level 0 immediately after a trigger, so later sequences trigger again.
- R8: With auto-rearm clear, the engine halts after one trigger. `trigOut` stays 0 and `curLevel` stays 0 until `arm` goes low and then high again.
- R9: Lowering `arm` returns the level to 0, gates `trigOut` to 0 and forgets the edge history.
- R10: Configuration writes presented while `arm` is high are ignored.
- R11: A write with `cfgWe` high stores `cfgData` according to `cfgField`. Codes 0, 1, 2 and 3 select the value, care, rise-enable and fall-enable words of level `cfgLevel`. Code 4 selects the control word, and `cfgLevel` is ignored for it. In the control word, bits [LVLW-1:0] hold the last-level index, saturated to LEVELS-1, and bit LVLW is auto-rearm. Everything resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Qualifies `sampleData` this cycle |
| sampleData | input | LINES | Sampled digital lines |
| cfgWe | input | 1 | Configuration write strobe |
| cfgLevel | input | LVLW | Level addressed by a per-level write |
| cfgField | input | 3 | Field code of the write (see R11) |
| cfgData | input | LINES | Write data |
| arm | input | 1 | High to hunt; low to reset the sequence |
| trigOut | output | 1 | Trigger pulse |
| curLevel | output | LVLW | Level currently being hunted |

## Verification
The bench builds the engine with 12 lines and 5 levels. Because a 5-level chain gives a 3-bit level index that is not a power of two, a control write with index 7 exercises the saturation. It also covers the padded slots of the level-hit vector. With 12 lines, random care masks of a few bits and sparse edge enables still match often enough that random runs reach every level, every last-level choice and both rearm modes within a few thousand cycles.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

  // Field codes of the configuration write port
  typedef enum logic [2:0] {
    FLD_VALUE = 3'd0,
    FLD_CARE  = 3'd1,
    FLD_RISE  = 3'd2,
    FLD_FALL  = 3'd3,
    FLD_CTRL  = 3'd4
  } cfgField_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic cfgWrite;   // accepted configuration write
    logic histLoad;   // capture current sample as edge history
    logic histClear;  // forget edge history
  } dpStrobe_t;

endpackage

// File: rtl/trig_seq_dp.sv
module trig_seq_dp
  import trig_seq_pkg::*;
#(
  parameter int LINES  = 36,
  parameter int LEVELS = 12,
  parameter int LVLW   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [LINES-1:0] sampleData,
  input  logic [LVLW-1:0]  cfgLevel,
  input  logic [2:0]       cfgField,
  input  logic [LINES-1:0] cfgData,
  input  logic [LVLW-1:0]  curLevel,
  output logic             levelHit,
  output logic [LVLW-1:0]  lastLevel,
  output logic             autoRearm
);

  localparam int SLOTS = 1 << LVLW;
  localparam logic [LVLW-1:0] TOP_LEVEL = LVLW'(LEVELS - 1);

  cfgField_e fieldSel;
  assign fieldSel = cfgField_e'(cfgField);

  // Edge history
  logic [LINES-1:0] prevQ;
  logic             haveQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevQ <= '0;
      haveQ <= 1'b0;
    end else if (strobe.histClear) begin
      haveQ <= 1'b0;
    end else if (strobe.histLoad) begin
      prevQ <= sampleData;
      haveQ <= 1'b1;
    end
  end

  // Global control word
  logic [LVLW-1:0] lastQ;
  logic            rearmQ;
  logic [LVLW-1:0] lastIn;
  assign lastIn = (cfgData[LVLW-1:0] > TOP_LEVEL) ? TOP_LEVEL : cfgData[LVLW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastQ  <= '0;
      rearmQ <= 1'b0;
    end else if (strobe.cfgWrite && fieldSel == FLD_CTRL) begin
      lastQ  <= lastIn;
      rearmQ <= cfgData[LVLW];
    end
  end

  assign lastLevel = lastQ;
  assign autoRearm = rearmQ;

  // Per-level condition storage and match evaluation
  logic [SLOTS-1:0] hitVec;

  for (genvar g = 0; g < SLOTS; g++) begin : g_lvl
    if (g < LEVELS) begin : g_used
      logic [LINES-1:0] valQ, careQ, riseQ, fallQ;
      logic             selMe;
      logic             patOk, riseOk, fallOk, edgeUsed;

      assign selMe = strobe.cfgWrite && (cfgLevel == LVLW'(g));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          valQ  <= '0;
          careQ <= '0;
          riseQ <= '0;
          fallQ <= '0;
        end else if (selMe) begin
          case (fieldSel)
            FLD_VALUE: valQ  <= cfgData;
            FLD_CARE:  careQ <= cfgData;
            FLD_RISE:  riseQ <= cfgData;
            FLD_FALL:  fallQ <= cfgData;
            default:   ;
          endcase
        end
      end

      assign patOk    = ((sampleData ^ valQ) & careQ) == '0;
      assign riseOk   = (riseQ & ~(~prevQ & sampleData)) == '0;
      assign fallOk   = (fallQ & ~(prevQ & ~sampleData)) == '0;
      assign edgeUsed = |(riseQ | fallQ);
      assign hitVec[g] = patOk && riseOk && fallOk && (haveQ || !edgeUsed);
    end else begin : g_pad
      assign hitVec[g] = 1'b0;
    end
  end

  assign levelHit = hitVec[curLevel];

endmodule

// File: rtl/trig_seq_ctrl.sv
module trig_seq_ctrl
  import trig_seq_pkg::*;
#(
  parameter int LVLW = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            arm,
  input  logic            sampleValid,
  input  logic            cfgWe,
  input  logic            levelHit,
  input  logic [LVLW-1:0] lastLevel,
  input  logic            autoRearm,
  output dpStrobe_t       strobe,
  output logic [LVLW-1:0] curLevel,
  output logic            trigOut
);

  typedef enum logic [1:0] {S_OFF, S_HUNT, S_HALT} seqState_e;

  seqState_e       state;
  logic [LVLW-1:0] levelQ;
  logic            trigQ;
  logic            evalNow;

  assign evalNow = arm && (state != S_HALT) && sampleValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_OFF;
      levelQ <= '0;
      trigQ  <= 1'b0;
    end else begin
      trigQ <= 1'b0;
      if (!arm) begin
        state  <= S_OFF;
        levelQ <= '0;
      end else if (state != S_HALT) begin
        state <= S_HUNT;
        if (evalNow && levelHit) begin
          if (levelQ == lastLevel) begin
            trigQ  <= 1'b1;
            levelQ <= '0;
            if (!autoRearm) state <= S_HALT;
          end else begin
            levelQ <= levelQ + LVLW'(1);
          end
        end
      end
    end
  end

  always_comb begin
    strobe.cfgWrite  = cfgWe && !arm;
    strobe.histLoad  = arm && sampleValid;
    strobe.histClear = !arm;
  end

  assign curLevel = levelQ;
  assign trigOut  = trigQ && arm;

endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_seq_pkg::*;
#(
  parameter int LINES  = 36,
  parameter int LEVELS = 12,
  localparam int LVLW  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic [LINES-1:0] sampleData,
  input  logic             cfgWe,
  input  logic [LVLW-1:0]  cfgLevel,
  input  logic [2:0]       cfgField,
  input  logic [LINES-1:0] cfgData,
  input  logic             arm,
  output logic             trigOut,
  output logic [LVLW-1:0]  curLevel
);

  dpStrobe_t       strobe;
  logic            levelHit;
  logic [LVLW-1:0] lastLevel;
  logic            autoRearm;

  trig_seq_dp #(.LINES(LINES), .LEVELS(LEVELS), .LVLW(LVLW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleData(sampleData),
    .cfgLevel(cfgLevel), .cfgField(cfgField), .cfgData(cfgData),
    .curLevel(curLevel), .levelHit(levelHit), .lastLevel(lastLevel),
    .autoRearm(autoRearm)
  );

  trig_seq_ctrl #(.LVLW(LVLW)) u_ctrl (
    .clk(clk), .rstN(rstN), .arm(arm), .sampleValid(sampleValid),
    .cfgWe(cfgWe), .levelHit(levelHit), .lastLevel(lastLevel),
    .autoRearm(autoRearm), .strobe(strobe), .curLevel(curLevel),
    .trigOut(trigOut)
  );

endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk #(
  parameter int LVLW = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            arm,
  input logic            sampleValid,
  input logic            trigOut,
  input logic [LVLW-1:0] curLevel
);

  // R6: a trigger only follows a valid sample
  a_r6_trig_after_valid: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> $past(sampleValid));

  // R6: level is back at 0 while the pulse is visible
  a_r6_trig_level_zero: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> (curLevel == '0));

  // R9: disarm clears the level
  a_r9_disarm_clears: assert property (@(posedge clk) disable iff (!rstN)
    !arm |=> (curLevel == '0));

  // R9: no pulse unless armed at the previous edge
  a_r9_trig_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> $past(arm));

  // R5: no movement without a valid sample
  a_r5_hold_without_valid: assert property (@(posedge clk) disable iff (!rstN)
    (arm && !sampleValid) |=> $stable(curLevel));

  // R5: at most one level per sample
  a_r5_step_one: assert property (@(posedge clk) disable iff (!rstN)
    (arm && sampleValid) |=>
      ($stable(curLevel) || (curLevel == '0) ||
       (curLevel == $past(curLevel) + LVLW'(1))));

endmodule

bind trig_seq trig_seq_chk #(.LVLW(LVLW)) u_chk (
  .clk(clk), .rstN(rstN), .arm(arm), .sampleValid(sampleValid),
  .trigOut(trigOut), .curLevel(curLevel)
);

// File: tb/tb_trig_seq.sv
`timescale 1ns/1ps
module tb_trig_seq;

  localparam int L  = 12;
  localparam int NL = 5;
  localparam int LW = $clog2(NL);

  logic          clk = 1'b0;
  logic          rstN;
  logic          sampleValid;
  logic [L-1:0]  sampleData;
  logic          cfgWe;
  logic [LW-1:0] cfgLevel;
  logic [2:0]    cfgField;
  logic [L-1:0]  cfgData;
  logic          arm;
  logic          trigOut;
  logic [LW-1:0] curLevel;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  trig_seq #(.LINES(L), .LEVELS(NL)) dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .cfgWe(cfgWe), .cfgLevel(cfgLevel), .cfgField(cfgField), .cfgData(cfgData),
    .arm(arm), .trigOut(trigOut), .curLevel(curLevel)
  );

  // Reference model
  logic [L-1:0]  mVal [NL];
  logic [L-1:0]  mCare[NL];
  logic [L-1:0]  mRise[NL];
  logic [L-1:0]  mFall[NL];
  logic [LW-1:0] mLast;
  logic          mRearm;
  int            mLvl;
  logic          mDone, mHave, mTrig;
  logic [L-1:0]  mPrev;

  function automatic logic refHit(int l, logic [L-1:0] cur);
    if (((mRise[l] | mFall[l]) != '0) && !mHave) return 1'b0;
    if (((cur ^ mVal[l]) & mCare[l]) != '0) return 1'b0;
    if ((mRise[l] & ~(~mPrev & cur)) != '0) return 1'b0;
    if ((mFall[l] & ~(mPrev & ~cur)) != '0) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [LW-1:0] clampLast(logic [L-1:0] d);
    return (int'(d[LW-1:0]) > NL - 1) ? LW'(NL - 1) : d[LW-1:0];
  endfunction

  task automatic check(input logic cond, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Drive one cycle just after a falling edge, advance the model, check at next falling edge
  task automatic doCycle(input logic a, input logic v, input logic [L-1:0] d, input string tag);
    arm = a; sampleValid = v; sampleData = d;
    if (!a) begin
      mLvl = 0; mDone = 1'b0; mHave = 1'b0; mTrig = 1'b0;
    end else begin
      mTrig = 1'b0;
      if (v) begin
        if (!mDone && refHit(mLvl, d)) begin
          if (mLvl == int'(mLast)) begin
            mTrig = 1'b1; mLvl = 0;
            if (!mRearm) mDone = 1'b1;
          end else mLvl++;
        end
        mPrev = d; mHave = 1'b1;
      end
    end
    @(negedge clk);
    check(trigOut == mTrig, tag, "trigOut", int'(trigOut), int'(mTrig));
    check(int'(curLevel) == mLvl, tag, "curLevel", int'(curLevel), mLvl);
  endtask

  task automatic cfgPut(input logic a, input int l, input int f, input logic [L-1:0] d,
                        input string tag);
    cfgWe = 1'b1; cfgLevel = LW'(l); cfgField = 3'(f); cfgData = d;
    if (!a) begin
      case (f)
        0: mVal[l]  = d;
        1: mCare[l] = d;
        2: mRise[l] = d;
        3: mFall[l] = d;
        4: begin mLast = clampLast(d); mRearm = d[LW]; end
        default: ;
      endcase
    end
    doCycle(a, 1'b0, '0, tag);
    cfgWe = 1'b0;
  endtask

  task automatic clearLevels();
    for (int l = 0; l < NL; l++) begin
      cfgPut(1'b0, l, 0, '0, "R11");
      cfgPut(1'b0, l, 1, '0, "R11");
      cfgPut(1'b0, l, 2, '0, "R11");
      cfgPut(1'b0, l, 3, '0, "R11");
    end
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; arm = 1'b0; sampleValid = 1'b0; sampleData = '0;
    cfgWe = 1'b0; cfgLevel = '0; cfgField = '0; cfgData = '0;
    for (int l = 0; l < NL; l++) begin
      mVal[l] = '0; mCare[l] = '0; mRise[l] = '0; mFall[l] = '0;
    end
    mLast = '0; mRearm = 1'b0; mLvl = 0; mDone = 1'b0; mHave = 1'b0;
    mTrig = 1'b0; mPrev = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(trigOut == 1'b0, "R1", "trigOut", int'(trigOut), 0);
    check(curLevel == '0, "R1", "curLevel", int'(curLevel), 0);

    // R4: level 0 needs a rise on line 0, single-level chain, no rearm
    cfgPut(1'b0, 0, 2, 12'h001, "R11");
    cfgPut(1'b0, 0, 4, 12'h000, "R11");
    doCycle(1'b1, 1'b1, 12'h001, "R4");     // first sample: no edge possible
    check(trigOut == 1'b0, "R4", "first sample trig", int'(trigOut), 0);
    doCycle(1'b1, 1'b1, 12'h000, "R4");
    doCycle(1'b1, 1'b1, 12'h001, "R3");     // real rise -> trigger
    check(trigOut == 1'b1, "R3", "rise trig", int'(trigOut), 1);
    // R8: halted, further rises ignored
    doCycle(1'b1, 1'b1, 12'h000, "R8");
    doCycle(1'b1, 1'b1, 12'h001, "R8");
    check(trigOut == 1'b0, "R8", "halted trig", int'(trigOut), 0);
    doCycle(1'b0, 1'b0, '0, "R9");
    doCycle(1'b1, 1'b1, 12'h000, "R8");
    doCycle(1'b1, 1'b1, 12'h001, "R8");     // re-armed: triggers again
    check(trigOut == 1'b1, "R8", "retrigger after toggle", int'(trigOut), 1);
    doCycle(1'b0, 1'b0, '0, "R9");

    // Three-level chain: pattern, rise on line 4, fall on line 5 with line 6 high
    clearLevels();
    cfgPut(1'b0, 0, 1, 12'h00F, "R11");
    cfgPut(1'b0, 0, 0, 12'h005, "R11");
    cfgPut(1'b0, 1, 2, 12'h010, "R11");
    cfgPut(1'b0, 2, 3, 12'h020, "R11");
    cfgPut(1'b0, 2, 1, 12'h040, "R11");
    cfgPut(1'b0, 2, 0, 12'h040, "R11");
    cfgPut(1'b0, 0, 4, 12'h002, "R11");     // last = 2, no rearm
    doCycle(1'b1, 1'b1, 12'h000, "R5");
    doCycle(1'b1, 1'b1, 12'h010, "R5");     // level-1 event first: not counted
    check(curLevel == '0, "R5", "order", int'(curLevel), 0);
    doCycle(1'b1, 1'b0, 12'h005, "R5");     // not valid: ignored
    doCycle(1'b1, 1'b1, 12'hF05, "R2");     // don't-care lines differ, match
    check(curLevel == LW'(1), "R2", "masked match", int'(curLevel), 1);
    cfgPut(1'b1, 1, 2, 12'h000, "R10");     // ignored while armed
    doCycle(1'b1, 1'b1, 12'h000, "R10");    // would match if write took effect
    check(curLevel == LW'(1), "R10", "write ignored", int'(curLevel), 1);
    doCycle(1'b1, 1'b1, 12'h010, "R3");
    doCycle(1'b1, 1'b1, 12'h020, "R3");     // line 6 low: no match
    doCycle(1'b1, 1'b1, 12'h060, "R3");
    doCycle(1'b1, 1'b1, 12'h040, "R6");     // fall on 5 with 6 high
    check(trigOut == 1'b1, "R6", "final trig", int'(trigOut), 1);
    doCycle(1'b1, 1'b1, 12'h005, "R8");
    doCycle(1'b0, 1'b0, '0, "R9");
    // R9: disarm mid-sequence
    doCycle(1'b1, 1'b1, 12'h005, "R9");
    doCycle(1'b0, 1'b1, 12'h010, "R9");
    check(curLevel == '0, "R9", "disarm level", int'(curLevel), 0);

    // R7: auto-rearm, single level on line 0 high
    clearLevels();
    cfgPut(1'b0, 0, 1, 12'h001, "R11");
    cfgPut(1'b0, 0, 0, 12'h001, "R11");
    cfgPut(1'b0, 0, 4, 12'(1 << LW), "R11");
    for (int i = 0; i < 4; i++) begin
      doCycle(1'b1, 1'b1, 12'h001, "R7");
      check(trigOut == 1'b1, "R7", "repeat trig", int'(trigOut), 1);
    end
    doCycle(1'b0, 1'b0, '0, "R9");

    // R11: last index 7 saturates to 4; empty levels match anything
    clearLevels();
    cfgPut(1'b0, 0, 4, 12'h007, "R11");
    for (int i = 0; i < NL; i++) doCycle(1'b1, 1'b1, 12'(i), "R11");
    check(trigOut == 1'b1, "R11", "saturated last", int'(trigOut), 1);
    doCycle(1'b0, 1'b0, '0, "R9");

    // Random phases
    for (int ph = 0; ph < 12; ph++) begin
      for (int l = 0; l < NL; l++) begin
        cfgPut(1'b0, l, 0, 12'($urandom), "R11");
        cfgPut(1'b0, l, 1, 12'($urandom) & 12'($urandom) & 12'($urandom), "R11");
        cfgPut(1'b0, l, 2, ($urandom % 4 == 0) ? 12'(1 << ($urandom % L)) : 12'h000, "R11");
        cfgPut(1'b0, l, 3, ($urandom % 4 == 0) ? 12'(1 << ($urandom % L)) : 12'h000, "R11");
      end
      cfgPut(1'b0, 0, 4, 12'($urandom % 8) | 12'(($urandom % 2) << LW), "R11");
      for (int c = 0; c < 250; c++) begin
        if ($urandom % 50 == 0) doCycle(1'b0, 1'b0, '0, "R9");
        else if ($urandom % 40 == 0) cfgPut(1'b1, $urandom % NL, $urandom % 5, 12'($urandom), "R10");
        else doCycle(1'b1, ($urandom % 10) < 7, 12'($urandom), "R5");
      end
      doCycle(1'b0, 1'b0, '0, "R1");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule